// File: doc/BRIEF.md
# Regulator Clock-Fault Recovery Supervisor

This block is the control state machine that watches the switching clock of one regulator inside a power-management device and manages recovery when that clock goes bad. It walks through five operating states (OFF, RESET, DIAGNOSTIC, ACTIVE, SAFE). It drives the regulator enable, a reset output line and a one-cycle self-test start strobe. It also keeps a saturating count of failures. The analog regulator, the oscillator and the self-test engine stay outside the block and appear only as single-bit status flags.

A clock error only counts when the internal oscillator is reported good and software has not turned off clock monitoring. A qualified error forces SAFE and turns the regulator off. The route back depends on one configuration bit. When the regulator is a reset source, an undervoltage in SAFE sends the block to RESET. There the regulator is switched on again once its output has discharged and every clock monitor is good. After the output has ramped up with no undervoltage left, a self-test is launched. Passing leads to DIAGNOSTIC and then ACTIVE. Failing returns to SAFE and adds to the failure count. When the regulator is not a reset source, the block stays in SAFE and the regulator enable follows a software bit. Reaching the failure limit, or a ramp that does not finish in time, ends in OFF, which only power-on reset can leave.

Top module: `clkrec_supervisor`

## Requirements
- R1: After power-on reset (`rst` high for at least one clock) the state code is RESET (1), `reg_en_o`=0, `bist_start_o`=0, `err_cnt_o`=0 and `rst_o`=1. State codes: OFF=0, RESET=1, DIAGNOSTIC=2, ACTIVE=3, SAFE=4.
- R2: A qualified clock fault (`clk_err_i`=1, `osc_ok_i`=1, `mon_dis_i`=0) moves the block to SAFE on the next clock, or to OFF if R9 applies. This holds in RESET, DIAGNOSTIC and ACTIVE, and in SAFE while `reg_en_o`=1. On the same clock `reg_en_o` goes to 0 and `err_cnt_o` goes up by one.
- R3: `clk_err_i` has no effect while `osc_ok_i`=0 or `mon_dis_i`=1. In that case the state and `err_cnt_o` stay unchanged.
- R4: In SAFE with `rst_src_i`=1, `uv_i`=1 moves the block to RESET on the next clock with `reg_en_o`=0.
- R5: In RESET with the regulator off, `reg_en_o` rises on the next clock only when `below_restart_i`, `sync_ok_i`, `pll_ok_i` and `swclk_ok_i` are all 1.
- R6: In RESET with the regulator on, `ramp_done_i`=1 together with `uv_i`=0 makes `bist_start_o` high for exactly one clock on the next clock. The state stays RESET.
- R7: After the self-test starts, `bist_done_i`=1 with `bist_pass_i`=1 moves to DIAGNOSTIC on the next clock. DIAGNOSTIC lasts DIAG_LEN clocks and then becomes ACTIVE.
- R8: `bist_done_i`=1 with `bist_pass_i`=0 moves to SAFE on the next clock (or OFF per R9), with `reg_en_o`=0 and `err_cnt_o` up by one.
- R9: A failure (R2 or R8) that happens when `err_cnt_o`+1 >= `err_limit_i` moves to OFF instead of SAFE. The counter still increments and saturates at its maximum.
- R10: If `ramp_done_i` (with `uv_i`=0) is not seen within RAMP_TIMEOUT clocks after `reg_en_o` rises in RESET, the block enters OFF with `reg_en_o`=0 exactly RAMP_TIMEOUT clocks after the rise.
- R11: In SAFE with `rst_src_i`=0, `uv_i` is ignored and the state stays SAFE. `reg_en_o` takes the value of `sw_en_i` on the next clock.
- R12: OFF persists under any input until power-on reset, with `reg_en_o`=0 and `rst_o`=1.
- R13: `rst_o` is 1 exactly in RESET and OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| clk_err_i | input | 1 | Regulator switching-clock error flag |
| osc_ok_i | input | 1 | Internal oscillator good |
| mon_dis_i | input | 1 | Software bit: clock monitoring disabled |
| uv_i | input | 1 | Regulator output below undervoltage threshold |
| below_restart_i | input | 1 | Regulator output discharged below restart level |
| sync_ok_i | input | 1 | External sync input monitor good |
| pll_ok_i | input | 1 | PLL/VCO monitor good |
| swclk_ok_i | input | 1 | Switching-clock monitor good |
| ramp_done_i | input | 1 | Regulator output has ramped up |
| bist_done_i | input | 1 | Self-test finished |
| bist_pass_i | input | 1 | Self-test result, valid with bist_done_i |
| rst_src_i | input | 1 | Configuration: regulator acts as a reset source |
| sw_en_i | input | 1 | Software regulator enable, used in SAFE |
| err_limit_i | input | ERR_W | Failure count that triggers power-down |
| state_o | output | 3 | Current state code |
| reg_en_o | output | 1 | Regulator enable |
| rst_o | output | 1 | Reset output, high in RESET and OFF |
| bist_start_o | output | 1 | One-clock self-test start strobe |
| err_cnt_o | output | ERR_W | Saturating failure count |

## Verification
Every output comes from a register, so the effect of any input shows up one clock after the edge that samples it. The two windows are the exception: OFF appears RAMP_TIMEOUT clocks after the regulator enable rises, and ACTIVE appears DIAG_LEN clocks after DIAGNOSTIC is entered. The bench changes inputs just after a falling edge. It compares all outputs at the next falling edge against a cycle model that steps once per clock. For the two windows it checks the state one clock before the expected change and again at the change.

// File: rtl/clkrec_pkg.sv
package clkrec_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_RESET  = 3'd1,
        ST_DIAG   = 3'd2,
        ST_ACTIVE = 3'd3,
        ST_SAFE   = 3'd4
    } sup_state_e;

    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_RAMP = 2'd1,
        PH_BIST = 2'd2
    } rst_phase_e;

    typedef struct packed {
        logic clk_err;
        logic osc_ok;
        logic mon_dis;
    } clk_stat_t;

    typedef struct packed {
        logic below_restart;
        logic sync_ok;
        logic pll_ok;
        logic swclk_ok;
    } restart_stat_t;

    function automatic logic fault_qualified(clk_stat_t s);
        return s.clk_err & s.osc_ok & ~s.mon_dis;
    endfunction

    function automatic logic restart_ready(restart_stat_t r);
        return r.below_restart & r.sync_ok & r.pll_ok & r.swclk_ok;
    endfunction

    function automatic logic holds_reset(sup_state_e s);
        return (s == ST_RESET) || (s == ST_OFF);
    endfunction

endpackage

// File: rtl/clkrec_timer.sv
module clkrec_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/clkrec_errcnt.sv
module clkrec_errcnt #(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic [ERR_W-1:0] limit,
    output logic [ERR_W-1:0] cnt,
    output logic             at_limit
);
    localparam logic [ERR_W-1:0] MAXV = {ERR_W{1'b1}};

    logic [ERR_W:0] cnt_plus;

    assign cnt_plus = {1'b0, cnt} + 1'b1;
    assign at_limit = cnt_plus >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc && cnt != MAXV) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/clkrec_fsm.sv
module clkrec_fsm
    import clkrec_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  clk_stat_t     clk_stat,
    input  restart_stat_t rs_stat,
    input  logic          uv,
    input  logic          ramp_done,
    input  logic          bist_done,
    input  logic          bist_pass,
    input  logic          rst_src,
    input  logic          sw_en,
    input  logic          ramp_expired,
    input  logic          diag_expired,
    input  logic          err_at_limit,
    output sup_state_e    state,
    output logic          reg_en,
    output logic          bist_start,
    output logic          err_inc,
    output logic          ramp_run,
    output logic          diag_run
);
    sup_state_e state_d;
    rst_phase_e phase_q, phase_d;
    logic       reg_en_d, bist_d, fail, fault_hit;

    always_comb begin
        state_d   = state;
        phase_d   = phase_q;
        reg_en_d  = reg_en;
        bist_d    = 1'b0;
        fail      = 1'b0;
        fault_hit = fault_qualified(clk_stat) && (state != ST_OFF)
                    && ((state != ST_SAFE) || reg_en);
        if (fault_hit) begin
            fail = 1'b1;
        end else begin
            case (state)
                ST_RESET: begin
                    case (phase_q)
                        PH_WAIT: begin
                            if (restart_ready(rs_stat)) begin
                                reg_en_d = 1'b1;
                                phase_d  = PH_RAMP;
                            end
                        end
                        PH_RAMP: begin
                            if (ramp_done && !uv) begin
                                phase_d = PH_BIST;
                                bist_d  = 1'b1;
                            end else if (ramp_expired) begin
                                state_d  = ST_OFF;
                                reg_en_d = 1'b0;
                            end
                        end
                        PH_BIST: begin
                            if (bist_done) begin
                                if (bist_pass) state_d = ST_DIAG;
                                else           fail    = 1'b1;
                            end
                        end
                        default: phase_d = PH_WAIT;
                    endcase
                end
                ST_DIAG: begin
                    if (diag_expired) state_d = ST_ACTIVE;
                end
                ST_SAFE: begin
                    if (rst_src && uv) begin
                        state_d  = ST_RESET;
                        phase_d  = PH_WAIT;
                        reg_en_d = 1'b0;
                    end else begin
                        reg_en_d = sw_en;
                    end
                end
                default: ;
            endcase
        end
        if (fail) begin
            reg_en_d = 1'b0;
            state_d  = err_at_limit ? ST_OFF : ST_SAFE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_RESET;
            phase_q    <= PH_WAIT;
            reg_en     <= 1'b0;
            bist_start <= 1'b0;
        end else begin
            state      <= state_d;
            phase_q    <= phase_d;
            reg_en     <= reg_en_d;
            bist_start <= bist_d;
        end
    end

    assign err_inc  = fail;
    assign ramp_run = (state == ST_RESET) && (phase_q == PH_RAMP);
    assign diag_run = (state == ST_DIAG);
endmodule

// File: rtl/clkrec_supervisor.sv
module clkrec_supervisor
    import clkrec_pkg::*;
#(
    parameter int ERR_W        = 4,
    parameter int RAMP_TIMEOUT = 256,
    parameter int DIAG_LEN     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_err_i,
    input  logic             osc_ok_i,
    input  logic             mon_dis_i,
    input  logic             uv_i,
    input  logic             below_restart_i,
    input  logic             sync_ok_i,
    input  logic             pll_ok_i,
    input  logic             swclk_ok_i,
    input  logic             ramp_done_i,
    input  logic             bist_done_i,
    input  logic             bist_pass_i,
    input  logic             rst_src_i,
    input  logic             sw_en_i,
    input  logic [ERR_W-1:0] err_limit_i,
    output logic [2:0]       state_o,
    output logic             reg_en_o,
    output logic             rst_o,
    output logic             bist_start_o,
    output logic [ERR_W-1:0] err_cnt_o
);
    clk_stat_t     clk_stat;
    restart_stat_t rs_stat;
    sup_state_e    state;
    logic          ramp_run, diag_run, ramp_expired, diag_expired;
    logic          err_inc, err_at_limit;

    assign clk_stat.clk_err      = clk_err_i;
    assign clk_stat.osc_ok       = osc_ok_i;
    assign clk_stat.mon_dis      = mon_dis_i;
    assign rs_stat.below_restart = below_restart_i;
    assign rs_stat.sync_ok       = sync_ok_i;
    assign rs_stat.pll_ok        = pll_ok_i;
    assign rs_stat.swclk_ok      = swclk_ok_i;

    clkrec_fsm i_fsm (
        .clk          (clk),
        .rst          (rst),
        .clk_stat     (clk_stat),
        .rs_stat      (rs_stat),
        .uv           (uv_i),
        .ramp_done    (ramp_done_i),
        .bist_done    (bist_done_i),
        .bist_pass    (bist_pass_i),
        .rst_src      (rst_src_i),
        .sw_en        (sw_en_i),
        .ramp_expired (ramp_expired),
        .diag_expired (diag_expired),
        .err_at_limit (err_at_limit),
        .state        (state),
        .reg_en       (reg_en_o),
        .bist_start   (bist_start_o),
        .err_inc      (err_inc),
        .ramp_run     (ramp_run),
        .diag_run     (diag_run)
    );

    clkrec_timer #(.LIMIT(RAMP_TIMEOUT)) i_ramp_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (ramp_run),
        .expired (ramp_expired)
    );

    clkrec_timer #(.LIMIT(DIAG_LEN)) i_diag_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (diag_run),
        .expired (diag_expired)
    );

    clkrec_errcnt #(.ERR_W(ERR_W)) i_errcnt (
        .clk      (clk),
        .rst      (rst),
        .inc      (err_inc),
        .limit    (err_limit_i),
        .cnt      (err_cnt_o),
        .at_limit (err_at_limit)
    );

    assign state_o = state;
    assign rst_o   = holds_reset(state);
endmodule

// File: rtl/clkrec_checker.sv
module clkrec_checker #(
    parameter int ERR_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             clk_err_i,
    input logic             osc_ok_i,
    input logic             mon_dis_i,
    input logic             below_restart_i,
    input logic             sync_ok_i,
    input logic             pll_ok_i,
    input logic             swclk_ok_i,
    input logic [2:0]       state_o,
    input logic             reg_en_o,
    input logic             rst_o,
    input logic             bist_start_o,
    input logic [ERR_W-1:0] err_cnt_o
);
    localparam logic [2:0] S_OFF = 3'd0, S_RESET = 3'd1, S_DIAG = 3'd2,
                           S_ACTIVE = 3'd3, S_SAFE = 3'd4;

    assert_fault_to_safe_R2: assert property (@(posedge clk) disable iff (rst)
        (clk_err_i && osc_ok_i && !mon_dis_i && (state_o == S_DIAG || state_o == S_ACTIVE))
        |=> ((state_o == S_SAFE || state_o == S_OFF) && !reg_en_o));

    assert_masked_error_R3: assert property (@(posedge clk) disable iff (rst)
        (state_o == S_ACTIVE && (!osc_ok_i || mon_dis_i)) |=> (state_o == S_ACTIVE));

    assert_restart_gate_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(reg_en_o) && state_o == S_RESET)
        |-> $past(below_restart_i && sync_ok_i && pll_ok_i && swclk_ok_i));

    assert_bist_in_reset_R6: assert property (@(posedge clk) disable iff (rst)
        bist_start_o |-> (state_o == S_RESET && reg_en_o && rst_o));

    assert_count_monotonic_R9: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (err_cnt_o >= $past(err_cnt_o)));

    assert_off_terminal_R12: assert property (@(posedge clk) disable iff (rst)
        (state_o == S_OFF) |=> (state_o == S_OFF && !reg_en_o && rst_o && $stable(err_cnt_o)));
endmodule

bind clkrec_supervisor clkrec_checker #(.ERR_W(ERR_W)) i_clkrec_checker (
    .clk             (clk),
    .rst             (rst),
    .clk_err_i       (clk_err_i),
    .osc_ok_i        (osc_ok_i),
    .mon_dis_i       (mon_dis_i),
    .below_restart_i (below_restart_i),
    .sync_ok_i       (sync_ok_i),
    .pll_ok_i        (pll_ok_i),
    .swclk_ok_i      (swclk_ok_i),
    .state_o         (state_o),
    .reg_en_o        (reg_en_o),
    .rst_o           (rst_o),
    .bist_start_o    (bist_start_o),
    .err_cnt_o       (err_cnt_o)
);

// File: tb/test_clkrec_supervisor.sv
`timescale 1ns/1ps
module test_clkrec_supervisor;
    localparam int TO = 16;
    localparam int DL = 4;
    localparam int EW = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst;
    logic clk_err, osc_ok, mon_dis, uv, below, sync_ok, pll_ok, swclk_ok;
    logic ramp, bdone, bpass, rsrc, sw_en;
    logic [EW-1:0] lim;
    logic [2:0]    state_o;
    logic          reg_en_o, rst_o, bist_start_o;
    logic [EW-1:0] err_cnt_o;

    clkrec_supervisor #(.ERR_W(EW), .RAMP_TIMEOUT(TO), .DIAG_LEN(DL)) i_clkrec_supervisor (
        .clk(clk), .rst(rst), .clk_err_i(clk_err), .osc_ok_i(osc_ok), .mon_dis_i(mon_dis),
        .uv_i(uv), .below_restart_i(below), .sync_ok_i(sync_ok), .pll_ok_i(pll_ok),
        .swclk_ok_i(swclk_ok), .ramp_done_i(ramp), .bist_done_i(bdone), .bist_pass_i(bpass),
        .rst_src_i(rsrc), .sw_en_i(sw_en), .err_limit_i(lim), .state_o(state_o),
        .reg_en_o(reg_en_o), .rst_o(rst_o), .bist_start_o(bist_start_o), .err_cnt_o(err_cnt_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int m_st, m_ph, m_en, m_bs, m_err, m_t, m_d;

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_st = 1; m_ph = 0; m_en = 0; m_bs = 0; m_err = 0; m_t = 0; m_d = 0;
    endtask

    // Next-state rules written from R2..R13
    task automatic model_step();
        int nst = m_st, nph = m_ph, nen = m_en, nbs = 0, nt = m_t, nd = m_d;
        bit failf = 0;
        bit fault = clk_err && osc_ok && !mon_dis && m_st != 0 && (m_st != 4 || m_en == 1);
        if (m_st == 0) begin
        end else if (fault) begin
            failf = 1;
        end else begin
            case (m_st)
                1: begin
                    if (m_ph == 0) begin
                        if (below && sync_ok && pll_ok && swclk_ok) begin nen = 1; nph = 1; nt = 0; end
                    end else if (m_ph == 1) begin
                        if (ramp && !uv) begin nph = 2; nbs = 1; end
                        else if (m_t == TO - 1) begin nst = 0; nen = 0; end
                        else nt = m_t + 1;
                    end else begin
                        if (bdone) begin
                            if (bpass) begin nst = 2; nd = 0; end
                            else failf = 1;
                        end
                    end
                end
                2: if (m_d == DL - 1) nst = 3; else nd = m_d + 1;
                4: if (rsrc && uv) begin nst = 1; nph = 0; nen = 0; end else nen = int'(sw_en);
                default: ;
            endcase
        end
        if (failf) begin
            nen = 0;
            nst = (m_err + 1 >= int'(lim)) ? 0 : 4;
            if (m_err < (1 << EW) - 1) m_err = m_err + 1;
        end
        m_st = nst; m_ph = nph; m_en = nen; m_bs = nbs; m_t = nt; m_d = nd;
    endtask

    task automatic compare_all(input string tag);
        check({tag, " state"}, int'(state_o), m_st);
        check({tag, " reg_en"}, int'(reg_en_o), m_en);
        check({tag, " rst_o R13"}, int'(rst_o), (m_st == 0 || m_st == 1) ? 1 : 0);
        check({tag, " bist_start"}, int'(bist_start_o), m_bs);
        check({tag, " err_cnt"}, int'(err_cnt_o), m_err);
    endtask

    task automatic tick();
        if (rst) model_reset(); else model_step();
        @(negedge clk);
        compare_all("MODEL");
    endtask

    task automatic set_idle();
        clk_err = 0; osc_ok = 1; mon_dis = 0; uv = 0; below = 0;
        sync_ok = 1; pll_ok = 1; swclk_ok = 1; ramp = 0; bdone = 0; bpass = 0;
        rsrc = 0; sw_en = 0; lim = EW'(3);
    endtask

    task automatic do_reset();
        rst = 1; tick(); tick(); rst = 0;
    endtask

    task automatic randomize_inputs();
        clk_err  = ($urandom % 16) == 0;
        osc_ok   = ($urandom % 8) != 0;
        mon_dis  = ($urandom % 8) == 0;
        uv       = ($urandom % 4) == 0;
        below    = ($urandom % 2) == 0;
        sync_ok  = ($urandom % 8) != 0;
        pll_ok   = ($urandom % 8) != 0;
        swclk_ok = ($urandom % 8) != 0;
        ramp     = ($urandom % 4) == 0;
        bdone    = ($urandom % 3) == 0;
        bpass    = ($urandom % 4) != 0;
        sw_en    = ($urandom % 2) == 0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20231));
        set_idle();
        rst = 1;
        @(negedge clk);
        do_reset();
        check("R1 state", int'(state_o), 1);
        check("R1 reg_en", int'(reg_en_o), 0);
        check("R1 err", int'(err_cnt_o), 0);
        check("R1 bist", int'(bist_start_o), 0);
        check("R13 rst_o in RESET", int'(rst_o), 1);

        below = 1; sync_ok = 0; tick();
        check("R5 blocked by sync", int'(reg_en_o), 0);
        sync_ok = 1; tick();
        check("R5 enable", int'(reg_en_o), 1);
        below = 0;

        uv = 1; ramp = 1; tick();
        check("R6 blocked by uv", int'(bist_start_o), 0);
        uv = 0; tick();
        check("R6 strobe", int'(bist_start_o), 1);
        check("R6 state", int'(state_o), 1);
        ramp = 0; tick();
        check("R6 one cycle", int'(bist_start_o), 0);

        bdone = 1; bpass = 1; tick();
        check("R7 diag", int'(state_o), 2);
        bdone = 0;
        repeat (DL - 1) tick();
        check("R7 still diag", int'(state_o), 2);
        tick();
        check("R7 active", int'(state_o), 3);
        check("R13 rst_o active", int'(rst_o), 0);

        clk_err = 1; osc_ok = 0; tick();
        check("R3 osc bad", int'(state_o), 3);
        osc_ok = 1; mon_dis = 1; tick();
        check("R3 monitor off", int'(state_o), 3);
        check("R3 err", int'(err_cnt_o), 0);
        mon_dis = 0; tick();
        check("R2 safe", int'(state_o), 4);
        check("R2 reg_en", int'(reg_en_o), 0);
        check("R2 err", int'(err_cnt_o), 1);
        clk_err = 0;

        rsrc = 0; uv = 1; tick(); tick();
        check("R11 stays safe", int'(state_o), 4);
        sw_en = 1; tick();
        check("R11 sw enable", int'(reg_en_o), 1);
        check("R11 state", int'(state_o), 4);

        rsrc = 1; tick();
        check("R4 reset", int'(state_o), 1);
        check("R4 reg_en", int'(reg_en_o), 0);
        uv = 0; sw_en = 0;

        below = 1; tick(); below = 0; ramp = 1; tick(); ramp = 0;
        bdone = 1; bpass = 0; tick();
        check("R8 safe", int'(state_o), 4);
        check("R8 reg_en", int'(reg_en_o), 0);
        check("R8 err", int'(err_cnt_o), 2);
        bdone = 0;

        uv = 1; tick(); uv = 0;
        below = 1; tick(); below = 0; ramp = 1; tick(); ramp = 0;
        bdone = 1; bpass = 0; tick(); bdone = 0;
        check("R9 off", int'(state_o), 0);
        check("R9 err", int'(err_cnt_o), 3);

        for (int i = 0; i < 20; i++) begin
            randomize_inputs();
            tick();
            check("R12 state", int'(state_o), 0);
            check("R12 reg_en", int'(reg_en_o), 0);
            check("R12 rst_o", int'(rst_o), 1);
        end

        set_idle();
        do_reset();
        below = 1; tick(); below = 0;
        check("R10 enabled", int'(reg_en_o), 1);
        repeat (TO - 1) tick();
        check("R10 before timeout", int'(state_o), 1);
        tick();
        check("R10 off", int'(state_o), 0);
        check("R10 reg_en", int'(reg_en_o), 0);

        for (int ep = 0; ep < 8; ep++) begin
            set_idle();
            do_reset();
            rsrc = (ep % 2) == 1;
            lim  = EW'(3 + ep);
            for (int c = 0; c < 600; c++) begin
                randomize_inputs();
                tick();
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule